// File: doc/BRIEF.md
# Four-Operand Decimal Adder

This block sums four packed decimal operands of four digits each in a single pass and returns a four-digit decimal result together with a top carry digit. For each digit position, the four input nibbles are first reduced by carry-save compression to one binary column total between 0 and 36. Comparator flags then classify that total. The generate flags show how many decades the total has already crossed. The propagate flags show when the units remainder is near enough to the next decade that an incoming carry can push it over.

The carry between adjacent digits can be 0, 1, 2 or 3. Each digit's flags therefore describe a mapping from incoming carry to outgoing carry. A parallel-prefix network composes these mappings, so every digit's incoming carry is known at once with no ripple. A correction stage then removes the right multiple of ten from each column. The result can be taken combinationally, or after one clock when the output register is selected.

Top module: `quad_bcd_adder`

## Requirements
- R1: Each 16-bit port `opA`..`opD` carries four decimal digits, with digit k held in bits [4k+3:4k]. The block returns the total of the four operands modulo 10000 on `sumOut` in the same digit layout, and the total divided by 10000 (rounded down) on `carryOut`. When all operands are zero, both outputs are zero.
- R2: The binary column total of each digit position is never larger than 36 while all input digits are valid (0 to 9).
- R3: A column total above 9, above 19 or above 29 adds one to that digit's outgoing carry for each of these thresholds it exceeds. For example, a lowest column of 9+9+9+3 = 30 gives lowest digit 0 and a carry of 3.
- R4: A digit's outgoing carry is one larger than its threshold count exactly when the units remainder plus the incoming carry reaches ten. This occurs for remainder 7 with carry 3, remainder 8 with carry of at least 2, and remainder 9 with carry of at least 1.
- R5: Each output digit equals column total plus incoming carry minus ten times outgoing carry, and always lies in 0 to 9.
- R6: The carry into the lowest digit is zero. Carries between digits take every value from 0 to 3, including a carry of 3 arriving at a column whose total is 17.
- R7: When all four operands are 9999, the output is `sumOut` = 9996 with `carryOut` = 3.
- R8: With `REG_OUT` = 1, the result appears one clock edge after the operands are applied, and the outputs hold their previous value until that edge. While `rstN` is low, both outputs are zero.
- R9: A carry travels across a whole run of 9 digits in one evaluation. For example, 9999 + 0001 + 0 + 0 gives `sumOut` = 0000 with `carryOut` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand, four decimal digits |
| opB | input | 16 | Second operand, four decimal digits |
| opC | input | 16 | Third operand, four decimal digits |
| opD | input | 16 | Fourth operand, four decimal digits |
| sumOut | output | 16 | Four-digit decimal result |
| carryOut | output | 2 | Top decimal carry, 0 to 3 |

## Verification
The hard case is a digit where a carry already generated inside the column meets a multi-valued carry coming from below, so the threshold count and the increment must both be resolved in the same evaluation. Directed operands are chosen to place a lower column at 36 or 20, giving a carry of 3 or 2, directly under a column whose total is 7, 8 or 17. Random valid operands add many further coincidences of this kind. Every cycle, the sum and top carry are compared against a plain integer reference, and each output digit is also checked to be a valid decimal digit.

// File: rtl/qbcd_pkg.sv
package qbcd_pkg;
  localparam int RAW_W = 6;
  localparam int CY_W  = 2;
  localparam int NUM_GEN  = 3;
  localparam int NUM_PROP = 9;

  typedef logic [CY_W-1:0]   carry_t;
  typedef logic [4*CY_W-1:0] cmap_t;   // entry for incoming carry c sits at [2c+1:2c]

  typedef struct packed {
    logic [NUM_GEN-1:0]  gen;    // gen[j]: column total > 10*j+9
    logic [NUM_PROP-1:0] prop;   // prop[k]: column total == 10*(k/3) + 7 + k%3
  } flags_t;

  typedef struct packed {
    carry_t cin;
    carry_t cout;
  } digitStrobe_t;

  function automatic cmap_t composeMap(cmap_t hi, cmap_t lo);
    cmap_t r;
    for (int c = 0; c < 4; c++) begin
      int idx;
      idx = int'(lo[2*c +: 2]);
      r[2*c +: 2] = hi[2*idx +: 2];
    end
    return r;
  endfunction

  function automatic cmap_t leafMap(flags_t f);
    cmap_t r;
    int g;
    int thr;
    g = 0;
    for (int j = 0; j < NUM_GEN; j++) g += int'(f.gen[j]);
    if (f.prop[0] | f.prop[3] | f.prop[6])      thr = 3;
    else if (f.prop[1] | f.prop[4] | f.prop[7]) thr = 2;
    else if (f.prop[2] | f.prop[5] | f.prop[8]) thr = 1;
    else                                        thr = 4;
    for (int c = 0; c < 4; c++) begin
      r[2*c +: 2] = CY_W'(g + ((c >= thr) ? 1 : 0));
    end
    return r;
  endfunction
endpackage

// File: rtl/qbcdDatapath.sv
module qbcdDatapath
  import qbcd_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [4*DIGITS-1:0]           opA,
  input  logic [4*DIGITS-1:0]           opB,
  input  logic [4*DIGITS-1:0]           opC,
  input  logic [4*DIGITS-1:0]           opD,
  input  digitStrobe_t [DIGITS-1:0]     strobes,
  output flags_t [DIGITS-1:0]           flags,
  output logic [4*DIGITS-1:0]           sumComb
);
  localparam int W = 4 * DIGITS;

  function automatic logic [2*RAW_W-1:0] csa3(logic [RAW_W-1:0] x,
                                              logic [RAW_W-1:0] y,
                                              logic [RAW_W-1:0] z);
    logic [RAW_W-1:0] s;
    logic [RAW_W-1:0] c;
    s = x ^ y ^ z;
    c = (x & y) | (x & z) | (y & z);
    return {c, s};
  endfunction

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [RAW_W-1:0] nA, nB, nC, nD;
    logic [RAW_W-1:0] s1, c1, s2, c2;
    logic [RAW_W-1:0] rawSum;
    logic [RAW_W-1:0] withCarry;
    logic [RAW_W-1:0] tenMult;
    logic [RAW_W-1:0] corrected;

    assign nA = RAW_W'(opA[4*d +: 4]);
    assign nB = RAW_W'(opB[4*d +: 4]);
    assign nC = RAW_W'(opC[4*d +: 4]);
    assign nD = RAW_W'(opD[4*d +: 4]);

    assign {c1, s1} = csa3(nA, nB, nC);
    assign {c2, s2} = csa3(s1, c1 << 1, nD);
    assign rawSum   = s2 + (c2 << 1);

    for (genvar j = 0; j < NUM_GEN; j++) begin : g_gen
      assign flags[d].gen[j] = (rawSum > RAW_W'(10 * j + 9));
    end
    for (genvar k = 0; k < NUM_PROP; k++) begin : g_prop
      assign flags[d].prop[k] = (rawSum == RAW_W'(10 * (k / 3) + 7 + (k % 3)));
    end

    assign withCarry = rawSum + RAW_W'(strobes[d].cin);
    assign tenMult   = RAW_W'(strobes[d].cout) * RAW_W'(10);
    assign corrected = withCarry - tenMult;
    assign sumComb[4*d +: 4] = corrected[3:0];

    // R5: correction never underflows and leaves a valid decimal digit
    p_digit_range_r5: assert property (@(posedge clk) disable iff (!rstN)
      (withCarry >= tenMult) && ((withCarry - tenMult) <= RAW_W'(9)))
      else $error("R5 digit %0d out of range", d);

    // R2: valid input digits keep the column total within 36
    p_raw_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
      ((nA <= 9) && (nB <= 9) && (nC <= 9) && (nD <= 9)) |-> (rawSum <= RAW_W'(36)))
      else $error("R2 column %0d total too large", d);
  end

  logic unusedBits;
  assign unusedBits = ^{W};
endmodule

// File: rtl/qbcdCarryNet.sv
module qbcdCarryNet
  import qbcd_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  flags_t [DIGITS-1:0]       flags,
  output digitStrobe_t [DIGITS-1:0] strobes
);
  localparam int LVL = (DIGITS > 1) ? $clog2(DIGITS) : 0;

  cmap_t stage [LVL+1][DIGITS];

  for (genvar i = 0; i < DIGITS; i++) begin : g_leaf
    assign stage[0][i] = leafMap(flags[i]);
  end

  for (genvar l = 0; l < LVL; l++) begin : g_level
    for (genvar i = 0; i < DIGITS; i++) begin : g_node
      if (i >= (1 << l)) begin : g_comb
        assign stage[l+1][i] = composeMap(stage[l][i], stage[l][i - (1 << l)]);
      end else begin : g_pass
        assign stage[l+1][i] = stage[l][i];
      end
    end
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_out
    carry_t genCount;
    logic   nearSeven, nearEight, nearNine;

    assign strobes[i].cout = stage[LVL][i][CY_W-1:0];
    if (i == 0) begin : g_low
      assign strobes[i].cin = '0;
    end else begin : g_up
      assign strobes[i].cin = stage[LVL][i-1][CY_W-1:0];
    end

    assign genCount  = CY_W'($countones(flags[i].gen));
    assign nearSeven = flags[i].prop[0] | flags[i].prop[3] | flags[i].prop[6];
    assign nearEight = flags[i].prop[1] | flags[i].prop[4] | flags[i].prop[7];
    assign nearNine  = flags[i].prop[2] | flags[i].prop[5] | flags[i].prop[8];

    // R3: carry out is the threshold count or one more
    p_carry_span_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].cout == genCount) || (strobes[i].cout == genCount + 2'd1))
      else $error("R3 carry out of digit %0d off its threshold count", i);

    // R4: the increment happens only on a near-decade remainder with enough carry in
    p_carry_bump_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[i].cout != genCount) |->
        ((nearSeven && strobes[i].cin == 2'd3) ||
         (nearEight && strobes[i].cin >= 2'd2) ||
         (nearNine  && strobes[i].cin >= 2'd1)))
      else $error("R4 unexpected carry increment at digit %0d", i);
  end
endmodule

// File: rtl/quad_bcd_adder.sv
module quad_bcd_adder
  import qbcd_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [4*DIGITS-1:0]   opA,
  input  logic [4*DIGITS-1:0]   opB,
  input  logic [4*DIGITS-1:0]   opC,
  input  logic [4*DIGITS-1:0]   opD,
  output logic [4*DIGITS-1:0]   sumOut,
  output logic [CY_W-1:0]       carryOut
);
  flags_t [DIGITS-1:0]       flags;
  digitStrobe_t [DIGITS-1:0] strobes;
  logic [4*DIGITS-1:0]       sumComb;

  qbcdDatapath #(.DIGITS(DIGITS)) u_datapath (
    .clk(clk), .rstN(rstN),
    .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .strobes(strobes), .flags(flags), .sumComb(sumComb)
  );

  qbcdCarryNet #(.DIGITS(DIGITS)) u_carryNet (
    .clk(clk), .rstN(rstN), .flags(flags), .strobes(strobes)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumOut   <= '0;
        carryOut <= '0;
      end else begin
        sumOut   <= sumComb;
        carryOut <= strobes[DIGITS-1].cout;
      end
    end

    // R1: all-zero operands give an all-zero result one clock later
    p_zero_in_r1: assert property (@(posedge clk) disable iff (!rstN)
      (opA == '0 && opB == '0 && opC == '0 && opD == '0) |=> (sumOut == '0 && carryOut == '0))
      else $error("R1 zero operands gave nonzero result");
  end else begin : g_comb
    assign sumOut   = sumComb;
    assign carryOut = strobes[DIGITS-1].cout;
  end
endmodule

// File: tb/quad_bcd_adder_bench.sv
module quad_bcd_adder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0, opC = '0, opD = '0;
  logic [15:0] sumOut;
  logic [1:0]  carryOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] prevS = '0;
  logic [1:0]  prevC = '0;

  always #10 clk = ~clk;

  quad_bcd_adder u_quad_bcd_adder (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opC(opC), .opD(opD),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic int bcdToInt(logic [15:0] v);
    int r = 0;
    for (int k = 3; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
    return r;
  endfunction

  function automatic logic [15:0] intToBcd(int v);
    logic [15:0] r;
    for (int k = 0; k < 4; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic logic [15:0] randBcd();
    logic [15:0] r;
    for (int k = 0; k < 4; k++) r[4*k +: 4] = 4'($urandom_range(0, 9));
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] actS, input logic [1:0] actC,
                       input logic [15:0] expS, input logic [1:0] expC);
    checks++;
    if (actS !== expS || actC !== expC) begin
      errors++;
      $display("FAIL %s actual=%h/%0d expected=%h/%0d", tag, actS, actC, expS, expC);
    end
  endtask

  task automatic checkDigits(input string tag);
    logic ok = 1'b1;
    for (int k = 0; k < 4; k++) if (sumOut[4*k +: 4] > 4'd9) ok = 1'b0;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=all digits 0..9", tag, sumOut);
    end
  endtask

  task automatic applyVec(input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] c, input logic [15:0] d, input string tag);
    int total;
    logic [15:0] expS;
    logic [1:0]  expC;
    @(negedge clk);
    opA = a; opB = b; opC = c; opD = d;
    total = bcdToInt(a) + bcdToInt(b) + bcdToInt(c) + bcdToInt(d);
    expS = intToBcd(total % 10000);
    expC = 2'(total / 10000);
    #1;
    check("R8 hold before edge", sumOut, carryOut, prevS, prevC);
    @(negedge clk);
    check(tag, sumOut, carryOut, expS, expC);
    checkDigits("R5 digit range");
    prevS = expS;
    prevC = expC;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    opA = 16'h9999; opB = 16'h9999; opC = 16'h9999; opD = 16'h9999;
    repeat (3) @(negedge clk);
    check("R8 reset clears outputs", sumOut, carryOut, 16'h0000, 2'd0);
    opA = '0; opB = '0; opC = '0; opD = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset state after release", sumOut, carryOut, 16'h0000, 2'd0);

    applyVec(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R1 zero operands");
    applyVec(16'h0001, 16'h0000, 16'h0000, 16'h0000, "R6 no carry into lowest digit");
    applyVec(16'h9999, 16'h9999, 16'h9999, 16'h9999, "R7 all nines");
    applyVec(16'h9999, 16'h0001, 16'h0000, 16'h0000, "R9 carry across nines");
    applyVec(16'h0009, 16'h0009, 16'h0009, 16'h0003, "R3 column of thirty");
    applyVec(16'h9090, 16'h9090, 16'h9090, 16'h9090, "R2 column of thirty-six");
    applyVec(16'h0079, 16'h0009, 16'h0009, 16'h0009, "R4 remainder 7 with carry 3");
    applyVec(16'h0089, 16'h0009, 16'h0002, 16'h0000, "R4 remainder 8 with carry 2");
    applyVec(16'h0099, 16'h0089, 16'h0009, 16'h0009, "R6 carry 3 into column 17");
    applyVec(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R1 zero again");
    for (int n = 0; n < 300; n++) begin
      applyVec(randBcd(), randBcd(), randBcd(), randBcd(), "R1 random operands");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule